// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a bus slave that holds the small control registers of a workstation I/O companion. These are the configuration, diagnostic, modem-control, two auxiliary, diagnostic-LED and system-control registers. An external address decoder selects one register window at a time through a one-hot window-select vector. Within the window, a short offset picks the word. Writes take effect on the clock edge that accepts them. Read data is registered and is presented in the cycle after the read strobe.

Several registers have side effects on write. The first auxiliary register turns one written bit into a one-clock terminal-count pulse for a floppy controller and does not store that bit. The second auxiliary register can request power-off. It also carries a sticky power-fail flag, which software clears by writing a dedicated bit. A write to the system-control register can request a system reset and leaves a reset-status value behind. A power-failing status input is synchronised and sets the flag. The flag, gated by a configuration enable bit, drives the power-fail interrupt. Reset clears only the configuration, modem and auxiliary registers, so diagnostic state and the reset status survive a reset.

Top module: `aux_sysctl_top`

## Requirements
- R1: Window select bit 0 is configuration, bit 1 diagnostic, bit 2 modem control, bit 3 auxiliary-1, bit 4 auxiliary-2, bit 5 LED and bit 6 system control. Configuration, diagnostic and modem control store wrData[7:0] and read back zero-extended on rdData in the cycle after rdEn.
- R2: A write to auxiliary-1 stores wrData[7:0] with bit 1 forced to 0. When wrData[1] is 1, tcPulse is high for exactly the one cycle after the accepting edge.
- R3: A write to auxiliary-2 stores only wrData[0] (power off). The stored bit 0 and the power-fail flag read back at bits 0 and 5. Bit 1 is never stored. When wrData[0] is 1, pwrOffReq is high for exactly one cycle after the accepting edge.
- R4: A write to auxiliary-2 with wrData[1]=1 clears the power-fail flag. With wrData[1]=0 the flag keeps its value.
- R5: After the synchronised pwrFailIn changes, the flag becomes 1 if pwrFailIn is 1 and configuration bit 3 is set, and 0 otherwise. The flag updates within 4 cycles of the input change.
- R6: pwrIrq is 1 exactly when the power-fail flag and configuration bit 3 are both 1. It follows configuration writes without any change to the flag.
- R7: The LED register stores wrData[15:0] at offset 0. Writes at a nonzero offset are ignored, and reads at a nonzero offset return 0.
- R8: A write to system control at offset 0 with wrData[0]=1 sets the register to 0x00000002 and makes sysRstReq high for exactly one cycle. Writes with wrData[0]=0 or at a nonzero offset change nothing. Nonzero offsets read as 0.
- R9: rstN low clears configuration, modem control, auxiliary-1 and auxiliary-2, including the flag. It leaves diagnostic, LED and system control unchanged.
- R10: Reads have no side effects: they raise no pulse and leave the flag and pwrIrq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winSel | input | 7 | One-hot register window select |
| offset | input | OFF_W | Word offset inside the selected window |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| pwrFailIn | input | 1 | Asynchronous power-failing status |
| pwrIrq | output | 1 | Power-fail interrupt |
| tcPulse | output | 1 | Floppy terminal-count pulse |
| pwrOffReq | output | 1 | Power-off request pulse |
| sysRstReq | output | 1 | System reset request pulse |

## Verification
The bench builds the block with DATA_W=32, OFF_W=2 and SYNC_STAGES=2. With these values, every one of the 256 byte values can be swept through each 8-bit register and both auxiliary registers, with the expected readback and pulses computed from the written value. The two-bit offset puts every nonzero offset of the LED and system-control windows within reach. The short synchroniser keeps the power-fail sequences of set, carry-over, clear, gated enable and reset to a few cycles each.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NUM_WIN = 7;
  localparam int WIN_CFG = 0;
  localparam int WIN_DIAG = 1;
  localparam int WIN_MODEM = 2;
  localparam int WIN_AUX1 = 3;
  localparam int WIN_AUX2 = 4;
  localparam int WIN_LED = 5;
  localparam int WIN_SYS = 6;

  localparam int CFG_PF_EN_BIT = 3;
  localparam int AUX1_TC_BIT = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_FLAG_BIT = 5;
  localparam int SYS_GO_BIT = 0;
  localparam int SYS_STATUS = 2;
  localparam int LED_W = 16;

  typedef struct packed {
    logic       wrCfg;
    logic       wrDiag;
    logic       wrModem;
    logic       wrAux1;
    logic       wrAux2;
    logic       wrLed;
    logic       wrSys;
    logic       rdStb;
    logic [2:0] rdWin;
    logic       offZero;
    logic       pfChange;
    logic       pfLevel;
  } ctrlStb_t;
endpackage

// File: rtl/aux_sysctl_ctrl.sv
module aux_sysctl_ctrl
  import aux_sysctl_pkg::*;
#(
  parameter int OFF_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_WIN-1:0] winSel,
  input  logic [OFF_W-1:0]   offset,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [1:0]         wrLow,
  input  logic               pwrFailIn,
  output ctrlStb_t           stb,
  output logic               tcPulse,
  output logic               pwrOffReq,
  output logic               sysRstReq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic syncQ [SYNC_STAGES];
  logic prevQ;
  logic [2:0] winCode;

  // Synchroniser chain for the power-failing input
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pwrFailIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  always_comb begin
    winCode = 3'd0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (winSel[i]) winCode = 3'(i);
    end
  end

  always_comb begin
    stb.offZero  = (offset == '0);
    stb.wrCfg    = wrEn && winSel[WIN_CFG];
    stb.wrDiag   = wrEn && winSel[WIN_DIAG];
    stb.wrModem  = wrEn && winSel[WIN_MODEM];
    stb.wrAux1   = wrEn && winSel[WIN_AUX1];
    stb.wrAux2   = wrEn && winSel[WIN_AUX2];
    stb.wrLed    = wrEn && winSel[WIN_LED] && stb.offZero;
    stb.wrSys    = wrEn && winSel[WIN_SYS] && stb.offZero;
    stb.rdStb    = rdEn && (winSel != '0);
    stb.rdWin    = winCode;
    stb.pfChange = syncQ[LAST] ^ prevQ;
    stb.pfLevel  = syncQ[LAST];
  end

  // Side-effect pulses, one clock wide, issued at the accepting edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcPulse   <= 1'b0;
      pwrOffReq <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      tcPulse   <= stb.wrAux1 && wrLow[AUX1_TC_BIT];
      pwrOffReq <= stb.wrAux2 && wrLow[AUX2_OFF_BIT];
      sysRstReq <= stb.wrSys && wrLow[SYS_GO_BIT];
    end
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwrIrq
);
  logic [7:0]        cfgQ;
  logic [7:0]        diagQ;
  logic [7:0]        modemQ;
  logic [7:0]        aux1Q;
  logic              offQ;
  logic              flagQ;
  logic [LED_W-1:0]  ledQ;
  logic [DATA_W-1:0] sysQ;
  logic [DATA_W-1:0] rdMux;
  logic [7:0]        aux2View;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:LED_W];

  // Registers cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= 8'h00;
      modemQ <= 8'h00;
      aux1Q  <= 8'h00;
      offQ   <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (stb.wrCfg)   cfgQ   <= wrData[7:0];
      if (stb.wrModem) modemQ <= wrData[7:0];
      if (stb.wrAux1) begin
        aux1Q              <= wrData[7:0];
        aux1Q[AUX1_TC_BIT] <= 1'b0;
      end
      if (stb.wrAux2) offQ <= wrData[AUX2_OFF_BIT];
      if (stb.wrAux2 && wrData[AUX2_CLR_BIT]) flagQ <= 1'b0;
      else if (stb.pfChange) flagQ <= stb.pfLevel && cfgQ[CFG_PF_EN_BIT];
    end
  end

  // Registers that survive reset
  always_ff @(posedge clk) begin
    if (stb.wrDiag) diagQ <= wrData[7:0];
    if (stb.wrLed)  ledQ  <= wrData[LED_W-1:0];
    if (stb.wrSys && wrData[SYS_GO_BIT]) sysQ <= DATA_W'(SYS_STATUS);
  end

  always_comb begin
    aux2View = 8'h00;
    aux2View[AUX2_OFF_BIT]  = offQ;
    aux2View[AUX2_FLAG_BIT] = flagQ;
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdWin)
      3'(WIN_CFG):   rdMux = DATA_W'(cfgQ);
      3'(WIN_DIAG):  rdMux = DATA_W'(diagQ);
      3'(WIN_MODEM): rdMux = DATA_W'(modemQ);
      3'(WIN_AUX1):  rdMux = DATA_W'(aux1Q);
      3'(WIN_AUX2):  rdMux = DATA_W'(aux2View);
      3'(WIN_LED):   rdMux = stb.offZero ? DATA_W'(ledQ) : '0;
      3'(WIN_SYS):   rdMux = stb.offZero ? sysQ : '0;
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdMux;
  end

  assign pwrIrq = flagQ && cfgQ[CFG_PF_EN_BIT];
endmodule

// File: rtl/aux_sysctl_top.sv
module aux_sysctl_top
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_WIN-1:0] winSel,
  input  logic [OFF_W-1:0]   offset,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               pwrFailIn,
  output logic               pwrIrq,
  output logic               tcPulse,
  output logic               pwrOffReq,
  output logic               sysRstReq
);
  ctrlStb_t stb;

  aux_sysctl_ctrl #(.OFF_W(OFF_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .winSel(winSel), .offset(offset),
    .wrEn(wrEn), .rdEn(rdEn), .wrLow(wrData[1:0]), .pwrFailIn(pwrFailIn),
    .stb(stb), .tcPulse(tcPulse), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );

  aux_sysctl_regs #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .pwrIrq(pwrIrq)
  );
endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_WIN-1:0] winSel,
  input logic [OFF_W-1:0]   offset,
  input logic               wrEn,
  input logic               rdEn,
  input logic [DATA_W-1:0]  wrData,
  input logic               pwrIrq,
  input logic               tcPulse,
  input logic               pwrOffReq,
  input logic               sysRstReq
);
  AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel[WIN_AUX1] && wrData[AUX1_TC_BIT]) |=> tcPulse); // R2
  AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> $past(wrEn && winSel[WIN_AUX1] && wrData[AUX1_TC_BIT])); // R2
  AST_OFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel[WIN_AUX2] && wrData[AUX2_OFF_BIT]) |=> pwrOffReq); // R3
  AST_CLR_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel[WIN_AUX2] && wrData[AUX2_CLR_BIT]) |=> !pwrIrq); // R4
  AST_CFG_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel[WIN_CFG] && !wrData[CFG_PF_EN_BIT]) |=> !pwrIrq); // R6
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(wrEn && winSel[WIN_SYS] && offset == '0 && wrData[SYS_GO_BIT])); // R8
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> !(tcPulse || pwrOffReq || sysRstReq)); // R10
endmodule

bind aux_sysctl_top aux_sysctl_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) uChk (.*);

// File: tb/tb_aux_sysctl_top.sv
module tb_aux_sysctl_top;
  localparam int DW = 32;
  localparam int OW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] winSel = '0;
  logic [OW-1:0] offset = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic pwrFailIn = 1'b0;
  logic pwrIrq, tcPulse, pwrOffReq, sysRstReq;

  int checks = 0;
  int errors = 0;
  logic [2:0] pulseHi, pulseLo;
  logic [DW-1:0] rv;

  aux_sysctl_top #(.DATA_W(DW), .OFF_W(OW), .SYNC_STAGES(2)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pulses packed as {tc, off, rst}
  task automatic wr(input int win, input int off, input logic [DW-1:0] d);
    @(negedge clk);
    winSel = 7'(1 << win); offset = OW'(off); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; winSel = '0;
    pulseHi = {tcPulse, pwrOffReq, sysRstReq};
    @(negedge clk);
    pulseLo = {tcPulse, pwrOffReq, sysRstReq};
  endtask

  task automatic rd(input int win, input int off, output logic [DW-1:0] d);
    @(negedge clk);
    winSel = 7'(1 << win); offset = OW'(off); rdEn = 1'b1;
    @(negedge clk);
    d = rdData; rdEn = 1'b0; winSel = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R9 reset state of the cleared registers
    rd(0, 0, rv); chk("R9 cfg after reset", rv, 0);
    rd(4, 0, rv); chk("R9 aux2 after reset", rv, 0);
    chk("R9 irq after reset", {31'b0, pwrIrq}, 0);

    // R1 sweep of the plain byte registers
    for (int w = 0; w < 3; w++) begin
      for (int v = 0; v < 256; v++) begin
        wr(w, v & 3, DW'(v) | 32'hABCD_0000);
        rd(w, 0, rv);
        chk($sformatf("R1 win%0d value %0d", w, v), rv, DW'(v));
      end
    end
    wr(0, 0, 0);

    // R2 auxiliary-1 sweep
    for (int v = 0; v < 256; v++) begin
      wr(3, 0, DW'(v));
      chk($sformatf("R2 tc pulse v=%0d", v), {31'b0, pulseHi[2]}, DW'((v >> 1) & 1));
      chk("R2 tc single cycle", {31'b0, pulseLo[2]}, 0);
      rd(3, 0, rv);
      chk($sformatf("R2 aux1 read v=%0d", v), rv, DW'(v & 8'hFD));
    end

    // R3 auxiliary-2 sweep with the flag clear
    for (int v = 0; v < 256; v++) begin
      wr(4, 0, DW'(v));
      chk($sformatf("R3 off pulse v=%0d", v), {31'b0, pulseHi[1]}, DW'(v & 1));
      chk("R3 off single cycle", {31'b0, pulseLo[1]}, 0);
      rd(4, 0, rv);
      chk($sformatf("R3 aux2 read v=%0d", v), rv, DW'(v & 1));
    end
    wr(4, 0, 0);

    // R7 LED register
    wr(5, 0, 32'h1234_BEEF);
    rd(5, 0, rv); chk("R7 led offset0", rv, 32'h0000_BEEF);
    for (int o = 1; o < 4; o++) begin
      wr(5, o, 32'h0000_5555);
      rd(5, o, rv); chk("R7 led nonzero offset reads 0", rv, 0);
      rd(5, 0, rv); chk("R7 led write at nonzero offset ignored", rv, 32'h0000_BEEF);
    end

    // R8 system control
    wr(6, 0, 32'hFFFF_FFFF);
    chk("R8 reset request pulse", {29'b0, pulseHi}, 3'b001);
    chk("R8 reset request single cycle", {29'b0, pulseLo}, 0);
    rd(6, 0, rv); chk("R8 status value", rv, 32'h2);
    wr(6, 0, 32'hFFFF_FFFE);
    chk("R8 bit0 clear no pulse", {31'b0, pulseHi[0]}, 0);
    rd(6, 0, rv); chk("R8 bit0 clear unchanged", rv, 32'h2);
    wr(6, 1, 32'h1);
    chk("R8 nonzero offset no pulse", {31'b0, pulseHi[0]}, 0);
    rd(6, 1, rv); chk("R8 nonzero offset reads 0", rv, 0);

    // R5 / R6 power-fail flag and interrupt
    wr(0, 0, 32'h08);
    @(negedge clk); pwrFailIn = 1'b1;
    idle(5);
    chk("R6 irq after power fail", {31'b0, pwrIrq}, 1);
    rd(4, 0, rv); chk("R5 flag set", rv, 32'h20);
    wr(4, 0, 32'h0);
    rd(4, 0, rv); chk("R4 flag carried over", rv, 32'h20);
    // R10 reads change nothing
    rd(3, 0, rv); rd(6, 0, rv); rd(4, 0, rv);
    chk("R10 reads raise no pulse", {29'b0, tcPulse, pwrOffReq, sysRstReq}, 0);
    chk("R10 reads keep flag", rv, 32'h20);
    chk("R10 reads keep irq", {31'b0, pwrIrq}, 1);
    wr(0, 0, 32'h00);
    chk("R6 irq masked by cfg", {31'b0, pwrIrq}, 0);
    rd(4, 0, rv); chk("R6 flag kept while masked", rv, 32'h20);
    wr(0, 0, 32'h08);
    chk("R6 irq back on enable", {31'b0, pwrIrq}, 1);
    wr(4, 0, 32'h2);
    chk("R4 clear drops irq", {31'b0, pwrIrq}, 0);
    rd(4, 0, rv); chk("R4 flag cleared, bit1 not stored", rv, 0);
    // falling input clears
    @(negedge clk); pwrFailIn = 1'b0; idle(5);
    @(negedge clk); pwrFailIn = 1'b1; idle(5);
    rd(4, 0, rv); chk("R5 flag set again", rv, 32'h20);
    @(negedge clk); pwrFailIn = 1'b0; idle(5);
    rd(4, 0, rv); chk("R5 falling input clears flag", rv, 0);
    chk("R5 irq low after fall", {31'b0, pwrIrq}, 0);
    // enable off: rising input does not set
    wr(0, 0, 32'h00);
    @(negedge clk); pwrFailIn = 1'b1; idle(5);
    rd(4, 0, rv); chk("R5 disabled input leaves flag clear", rv, 0);
    wr(0, 0, 32'h08);
    chk("R6 no irq without flag", {31'b0, pwrIrq}, 0);
    @(negedge clk); pwrFailIn = 1'b0; idle(5);

    // R9 selective reset
    wr(0, 0, 32'h77); wr(1, 0, 32'h5A); wr(2, 0, 32'h33);
    wr(3, 0, 32'h81); wr(4, 0, 32'h01); wr(5, 0, 32'hCAFE);
    wr(6, 0, 32'h1);
    @(negedge clk); rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    rd(0, 0, rv); chk("R9 cfg cleared", rv, 0);
    rd(2, 0, rv); chk("R9 modem cleared", rv, 0);
    rd(3, 0, rv); chk("R9 aux1 cleared", rv, 0);
    rd(4, 0, rv); chk("R9 aux2 cleared", rv, 0);
    rd(1, 0, rv); chk("R9 diag kept", rv, 32'h5A);
    rd(5, 0, rv); chk("R9 led kept", rv, 32'hCAFE);
    rd(6, 0, rv); chk("R9 status survives reset", rv, 32'h2);

    finishRun();
  end
endmodule